// File: doc/BRIEF.md
# Row-by-row double-sampling pixel readout sequencer

This controller walks a pixel matrix one row at a time. For each row it drives the row gate, fires a first sample strobe while the row carries signal plus baseline, pulses a full row clear, and fires a second sample strobe that sees the baseline alone. The analog front end subtracts the two samples, so no per-pixel baseline table is ever stored. The sequencer then strobes the hit comparators, captures their per-column result as the row's hit mask, and writes it with the row number into a small row FIFO before moving on to the next row.

Work is split between two windows. While `beam_active` is high the sequencer steps through rows and fills the FIFO. While it is low the sequencer freezes in place with every strobe released, and the FIFO may be drained one entry per read. Each of the six per-row phases has its own programmable length. A full FIFO at push time holds the sequencer in the compare phase, and a stall that lasts too long is counted. The nominal sequencing clock is 50 MHz.

Top module: `pixrow_seq`

## Requirements
- R1: Within a row the phases run in the fixed order select, first sample, clear, second sample, compare, push. `row_sel` is the one-hot code of `row_idx` (bit n set for row n) through the first four phases and is all zero in compare and push. `samp_a`, `row_clear`, `samp_b` and `cmp_strobe` are high only in their own phase.
- R2: Each phase lasts as many cycles as its length input. A length of 0 counts as 1.
- R3: In the last compare cycle, `hit_in` (bit n = column n) is written with the row number into the FIFO. Reads return entries in write order as `rd_row` and `rd_mask`.
- R4: `row_idx` counts up from 0, advancing after each push phase, and wraps from ROWS-1 to 0. `frame_done` is high for exactly the last push cycle of row ROWS-1.
- R5: While `beam_active` is low the sequencer holds its row, phase and cycle count. `row_sel`, all strobes and `frame_done` are low and nothing is written. Raising `beam_active` again resumes in the same cycle of the same phase.
- R6: `rd_en` is accepted only while `beam_active` is low. While the window is open it has no effect.
- R7: When the FIFO is full at the end of the compare phase, the sequencer stays in compare with `cmp_strobe` high and writes the row once space frees, losing no row.
- R8: `ovf_cnt` increases by exactly one per stall event, in the stall's cycle number `stall_limit` (the first stalled cycle is number 0).
- R9: After reset `row_idx` is 0, the FIFO is empty, `ovf_cnt` is 0, and `rd_valid`, `row_sel`, the strobes and `frame_done` are low.
- R10: An accepted read raises `rd_valid` for one cycle, one cycle later, with the data. A read of an empty FIFO raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beam_active | input | 1 | High: sequence and write; low: freeze and allow reads |
| len_sel | input | LEN_W | Select phase length in cycles |
| len_samp_a | input | LEN_W | First sample phase length |
| len_clear | input | LEN_W | Clear phase length |
| len_samp_b | input | LEN_W | Second sample phase length |
| len_cmp | input | LEN_W | Compare phase length |
| len_push | input | LEN_W | Push phase length |
| stall_limit | input | STALL_W | Stalled cycles before an overflow is counted |
| hit_in | input | COLS | Comparator result per column |
| row_sel | output | ROWS | One-hot row gate |
| row_idx | output | ROW_W | Current row number |
| samp_a | output | 1 | Signal plus baseline sample strobe |
| row_clear | output | 1 | Row clear pulse |
| samp_b | output | 1 | Baseline-only sample strobe |
| cmp_strobe | output | 1 | Comparator strobe |
| frame_done | output | 1 | One-cycle end-of-frame marker |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read data valid |
| rd_row | output | ROW_W | Row number of the entry read |
| rd_mask | output | COLS | Hit mask of the entry read |
| ovf_cnt | output | OVF_W | Count of overlong stalls |

## Verification
The collision of interest is the active window closing in the very cycle a row's push is due. The bench drops `beam_active` exactly on the last compare cycle of a row. It then requires that the strobes fall at once and that no entry for that row appears among the reads made in the gap. When the window reopens, `cmp_strobe` must return in that same cycle, and the row must be written with the hit mask that is present at resumption, not the one present when the window closed. The scoreboard's ordered queue of rows and masks judges the outcome.

// File: rtl/pixrow_seq.sv
module pixrow_seq #(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int DEPTH   = 4,
  parameter int LEN_W   = 4,
  parameter int STALL_W = 8,
  parameter int OVF_W   = 8,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beam_active,
  input  logic [LEN_W-1:0]   len_sel,
  input  logic [LEN_W-1:0]   len_samp_a,
  input  logic [LEN_W-1:0]   len_clear,
  input  logic [LEN_W-1:0]   len_samp_b,
  input  logic [LEN_W-1:0]   len_cmp,
  input  logic [LEN_W-1:0]   len_push,
  input  logic [STALL_W-1:0] stall_limit,
  input  logic [COLS-1:0]    hit_in,
  output logic [ROWS-1:0]    row_sel,
  output logic [ROW_W-1:0]   row_idx,
  output logic               samp_a,
  output logic               row_clear,
  output logic               samp_b,
  output logic               cmp_strobe,
  output logic               frame_done,
  input  logic               rd_en,
  output logic               rd_valid,
  output logic [ROW_W-1:0]   rd_row,
  output logic [COLS-1:0]    rd_mask,
  output logic [OVF_W-1:0]   ovf_cnt
);
  typedef enum logic [2:0] {P_SEL, P_SMPA, P_CLR, P_SMPB, P_CMP, P_PUSH} phase_t;

  phase_t               phase;
  logic [LEN_W-1:0]     ph_cnt, len_cur;
  logic                 last, full, empty, wr, stalled, advance, rd_fire, ovf_seen;
  logic [AW:0]          wp, rp;
  logic [STALL_W-1:0]   stall_cnt;
  logic [ROW_W+COLS-1:0] mem [DEPTH];

  always_comb begin
    case (phase)
      P_SEL:   len_cur = len_sel;
      P_SMPA:  len_cur = len_samp_a;
      P_CLR:   len_cur = len_clear;
      P_SMPB:  len_cur = len_samp_b;
      P_CMP:   len_cur = len_cmp;
      default: len_cur = len_push;
    endcase
  end

  assign last    = (len_cur == '0) ? (ph_cnt == '0) : (ph_cnt == len_cur - 1'b1);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty   = (wp == rp);
  assign stalled = beam_active && phase == P_CMP && last && full;
  assign wr      = beam_active && phase == P_CMP && last && !full;
  assign advance = beam_active && last && !stalled;
  assign rd_fire = rd_en && !beam_active && !empty;

  assign row_sel    = (beam_active && phase inside {P_SEL, P_SMPA, P_CLR, P_SMPB})
                      ? (ROWS'(1) << row_idx) : '0;
  assign samp_a     = beam_active && phase == P_SMPA;
  assign row_clear  = beam_active && phase == P_CLR;
  assign samp_b     = beam_active && phase == P_SMPB;
  assign cmp_strobe = beam_active && phase == P_CMP;
  assign frame_done = beam_active && phase == P_PUSH && last && row_idx == ROW_W'(ROWS-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_SEL;
      ph_cnt  <= '0;
      row_idx <= '0;
    end else if (advance) begin
      ph_cnt <= '0;
      case (phase)
        P_SEL:   phase <= P_SMPA;
        P_SMPA:  phase <= P_CLR;
        P_CLR:   phase <= P_SMPB;
        P_SMPB:  phase <= P_CMP;
        P_CMP:   phase <= P_PUSH;
        default: begin
          phase   <= P_SEL;
          row_idx <= (row_idx == ROW_W'(ROWS-1)) ? '0 : row_idx + 1'b1;
        end
      endcase
    end else if (beam_active && !stalled) begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= {row_idx, hit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      rd_valid <= 1'b0;
      rd_row   <= '0;
      rd_mask  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (wr) wp <= wp + 1'b1;
      if (rd_fire) begin
        rp                <= rp + 1'b1;
        {rd_row, rd_mask} <= mem[rp[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      ovf_seen  <= 1'b0;
      ovf_cnt   <= '0;
    end else if (beam_active && !stalled) begin
      stall_cnt <= '0;
      ovf_seen  <= 1'b0;
    end else if (stalled) begin
      if (stall_cnt != '1) stall_cnt <= stall_cnt + 1'b1;
      if (stall_cnt == stall_limit && !ovf_seen) begin
        ovf_cnt  <= ovf_cnt + 1'b1;
        ovf_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixrow_seq_chk.sv
module pixrow_seq_chk #(
  parameter int ROWS  = 8,
  parameter int OVF_W = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beam_active,
  input logic [ROWS-1:0]  row_sel,
  input logic [ROW_W-1:0] row_idx,
  input logic             samp_a,
  input logic             row_clear,
  input logic             samp_b,
  input logic             cmp_strobe,
  input logic             frame_done,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [OVF_W-1:0] ovf_cnt
);
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_a, row_clear, samp_b, cmp_strobe}) && $onehot0(row_sel));

  p_gate_during_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_a || row_clear || samp_b) |-> (row_sel != '0));

  p_gate_off_in_cmp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> (row_sel == '0));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !beam_active |-> (row_sel == '0 && !samp_a && !row_clear && !samp_b && !cmp_strobe && !frame_done));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !beam_active |=> $stable(row_idx));

  p_frame_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (row_idx == '0));

  p_no_read_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && beam_active) |=> !rd_valid);

  p_ovf_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_cnt) |-> (ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1)));
endmodule

bind pixrow_seq pixrow_seq_chk #(.ROWS(ROWS), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .beam_active(beam_active), .row_sel(row_sel),
  .row_idx(row_idx), .samp_a(samp_a), .row_clear(row_clear), .samp_b(samp_b),
  .cmp_strobe(cmp_strobe), .frame_done(frame_done), .rd_en(rd_en),
  .rd_valid(rd_valid), .ovf_cnt(ovf_cnt)
);

// File: tb/pixrow_seq_tb_top.sv
module pixrow_seq_tb_top;
  localparam int ROWS = 8, COLS = 8, ROW_W = 3, LEN_W = 4, STALL_W = 8, OVF_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, beam = 1'b0, rd_en = 1'b0;
  logic [LEN_W-1:0] l_sel = 2, l_a = 3, l_clr = 1, l_b = 2, l_cmp = 0, l_push = 2;
  logic [STALL_W-1:0] lim = 10;
  logic [COLS-1:0] hit_in;
  logic [ROWS-1:0] row_sel;
  logic [ROW_W-1:0] row_idx, rd_row;
  logic samp_a, row_clear, samp_b, cmp_strobe, frame_done, rd_valid;
  logic [COLS-1:0] rd_mask;
  logic [OVF_W-1:0] ovf_cnt;
  int seed = 0, n_cmp = 0, n_bad = 0, fd_cnt = 0;
  logic [ROW_W+COLS-1:0] sb_q[$];

  always #4 clk = ~clk;

  function automatic logic [COLS-1:0] pat(input int r, input int s);
    return COLS'((r * 37 + s * 91 + 5) ^ (r << 3));
  endfunction

  assign hit_in = pat(int'(row_idx), seed);

  pixrow_seq #(.ROWS(ROWS), .COLS(COLS), .DEPTH(4), .LEN_W(LEN_W),
               .STALL_W(STALL_W), .OVF_W(OVF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .beam_active(beam),
    .len_sel(l_sel), .len_samp_a(l_a), .len_clear(l_clr), .len_samp_b(l_b),
    .len_cmp(l_cmp), .len_push(l_push), .stall_limit(lim), .hit_in(hit_in),
    .row_sel(row_sel), .row_idx(row_idx), .samp_a(samp_a), .row_clear(row_clear),
    .samp_b(samp_b), .cmp_strobe(cmp_strobe), .frame_done(frame_done),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_row(rd_row), .rd_mask(rd_mask),
    .ovf_cnt(ovf_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_row(input int r, input int s);
    sb_q.push_back({ROW_W'(r), pat(r, s)});
  endtask

  task automatic read_n(input int n);
    rd_en = 1'b1;
    repeat (n) @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: R3 ordering and content, R10 no data from empty reads
  always @(negedge clk) begin
    if (rst_n && frame_done) fd_cnt++;
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) chk(1'b0, "R10 read without entry", {rd_row, rd_mask}, 0);
      else begin
        logic [ROW_W+COLS-1:0] e;
        e = sb_q.pop_front();
        chk({rd_row, rd_mask} == e, "R3 fifo entry", {rd_row, rd_mask}, e);
      end
    end
  end

  function automatic logic [31:0] exp_vec(input int c);
    int r, p;
    logic [ROWS-1:0] rs;
    r = c / 11;
    p = c % 11;
    rs = (p < 8) ? (ROWS'(1) << r) : '0;
    return {ROW_W'(r), rs, 1'(p >= 2 && p <= 4), 1'(p == 5), 1'(p == 6 || p == 7), 1'(p == 8)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(row_idx == 0 && row_sel == 0 && !rd_valid && ovf_cnt == 0, "R9 reset state",
        {row_idx, row_sel, rd_valid, ovf_cnt}, 0);
    chk(!samp_a && !row_clear && !samp_b && !cmp_strobe && !frame_done, "R9 strobes idle",
        {samp_a, row_clear, samp_b, cmp_strobe, frame_done}, 0);
    read_n(1);
    chk(!rd_valid, "R10 empty read", rd_valid, 0);

    expect_row(0, 0);
    expect_row(1, 0);
    beam = 1'b1;
    for (int c = 0; c < 22; c++) begin
      #2;
      // R1 order, R2 lengths (zero-length compare counts one), R4 row advance
      chk({row_idx, row_sel, samp_a, row_clear, samp_b, cmp_strobe} == exp_vec(c),
          "R1 R2 R4 phase timing", {row_idx, row_sel, samp_a, row_clear, samp_b, cmp_strobe}, exp_vec(c));
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    // last compare cycle of row 2: window closes where the push is due
    beam = 1'b0;
    #2;
    chk(!cmp_strobe && row_sel == 0, "R5 strobes released", {cmp_strobe, row_sel}, 0);
    @(negedge clk);
    seed = 1;
    read_n(3);
    chk(row_idx == 2, "R5 row held", row_idx, 2);
    chk(sb_q.size() == 0, "R5 no write while idle", sb_q.size(), 0);
    beam = 1'b1;
    #2;
    chk(cmp_strobe && row_idx == 2, "R5 resume in compare", {cmp_strobe, row_idx}, {1'b1, 3'd2});
    for (int r = 2; r < 6; r++) expect_row(r, 1);
    @(negedge clk);
    repeat (100) @(negedge clk);
    chk(cmp_strobe && row_idx == 6, "R7 stall in compare", {cmp_strobe, row_idx}, {1'b1, 3'd6});
    chk(ovf_cnt == 1, "R8 one overflow per stall", ovf_cnt, 1);
    chk(fd_cnt == 0, "R4 no early frame_done", fd_cnt, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(!rd_valid, "R6 read ignored in window", rd_valid, 0);
    beam = 1'b0;
    @(negedge clk);
    read_n(4);
    chk(sb_q.size() == 0, "R7 rows 2-5 drained", sb_q.size(), 0);
    expect_row(6, 1);
    expect_row(7, 1);
    expect_row(0, 1);
    expect_row(1, 1);
    beam = 1'b1;
    repeat (150) @(negedge clk);
    chk(fd_cnt == 1, "R4 single frame_done", fd_cnt, 1);
    chk(row_idx == 2 && cmp_strobe, "R4 wrap then stall", {row_idx, cmp_strobe}, {3'd2, 1'b1});
    chk(ovf_cnt == 2, "R8 second stall event", ovf_cnt, 2);
    beam = 1'b0;
    @(negedge clk);
    read_n(5);
    chk(sb_q.size() == 0, "R3 all rows returned", sb_q.size(), 0);
    chk(!rd_valid, "R10 no valid after empty", rd_valid, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule